// File: doc/BRIEF.md
# PLL Tuner Frequency Programmer

This block sets the local oscillator of an analog receiver's frequency synthesizer over a two-wire I2C bus. The user gives a receive frequency as an unsigned 16-bit count of 125 kHz steps and pulses a start strobe. The block adds a fixed high-side intermediate-frequency offset of 3836 steps (479.5 MHz) to form the synthesizer divider. It then performs one complete write transfer to the synthesizer.

The transfer carries an address byte, the divider with its high byte first, and two constant control bytes. The block includes its own open-drain bit engine. It checks the acknowledge after every byte and reports busy, a one-cycle done pulse and an error flag. The SCL period is four quarter-periods, and each quarter-period lasts `QDIV` system clocks.

Top module: `pll_tune_ctrl`

## Requirements
- R1: After reset, both bus lines are released (`scl_oe_o`=0, `sda_oe_o`=0) and `busy_o`, `done_o`, `err_o` are 0. The lines stay released whenever `busy_o` is 0.
- R2: The first byte after START is the 7-bit device address 0x61 with a write bit of 0, i.e. 0xC2, sent most significant bit first.
- R3: The divider equals the request code plus 3836. It is sent as two bytes, high byte first, directly after the address byte. Code 7280 gives 0x2B then 0x6C; code 0 gives 0x0E, 0xFC; code 61699 gives 0xFF, 0xFF.
- R4: After the divider bytes come the control bytes 0x8E and then 0xF0, whatever the code.
- R5: Each transfer has exactly one START (SDA falls while SCL is high) and exactly one STOP (SDA rises while SCL is high). SDA changes at no other time while SCL is high.
- R6: On the ninth clock of each byte the block releases SDA and samples it while SCL is high. A high level (NACK) ends the transfer with STOP after that byte, sends no further bytes and sets `err_o`.
- R7: A code above 61699 makes the divider overflow 16 bits. In that case no bus activity occurs, `busy_o` stays 0, and in the next cycle `done_o` pulses with `err_o`=1.
- R8: An accepted request holds `busy_o` high for exactly Q×`QDIV` cycles, where Q = 4 + 36·n + 4 quarter-periods and n is the number of bytes sent (5 when all are acknowledged). `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls.
- R9: A start strobe while `busy_o` is 1 is ignored, including in the last busy cycle. The bytes on the bus are unchanged and no second transfer follows.
- R10: An accepted request clears `err_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| rx_code_i | input | 16 | Receive frequency in 125 kHz steps |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Overflow or NACK seen on the last request |

## Verification
The completion of a transfer and a fresh start strobe can land in the same cycle. The bench sends a strobe in the final busy cycle, when STOP is completing and done is about to pulse. It expects that strobe to be dropped, with `busy_o` staying low afterwards. It also places a strobe in the middle of a transfer and requires the frame on the bus to be unchanged. A behavioural model predicts `busy_o` and `done_o` on every clock from the code and from where the bench's slave withholds its acknowledge, so any stray or missing cycle shows up as a mismatch.

// File: rtl/pll_tune_pkg.sv
package pll_tune_pkg;

    localparam int DIV_W     = 16;
    localparam int NBYTES    = 5;
    localparam int IDX_W     = 3;
    localparam int BIT_W     = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BITS  = 2'd2,
        PH_STOP  = 2'd3
    } xfer_st_e;

    typedef struct packed {
        xfer_st_e          st;
        logic [1:0]        qtr;
        logic [BIT_W-1:0]  bitn;
        logic [IDX_W-1:0]  byten;
        logic [DIV_W-1:0]  div;
        logic [7:0]        sh;
        logic              nack;
        logic              busy;
        logic              done;
        logic              err;
    } tune_state_t;

endpackage

// File: rtl/pt_quarter_tick.sv
module pt_quarter_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/pt_divider_calc.sv
module pt_divider_calc #(
    parameter int DIV_W    = 16,
    parameter int IF_STEPS = 3836
) (
    input  logic [DIV_W-1:0] code,
    output logic [DIV_W-1:0] div,
    output logic             ovf
);
    logic [DIV_W:0] sum;

    assign sum = {1'b0, code} + (DIV_W+1)'(IF_STEPS);
    assign div = sum[DIV_W-1:0];
    assign ovf = sum[DIV_W];
endmodule

// File: rtl/pt_frame_mux.sv
module pt_frame_mux #(
    parameter int         DIV_W    = 16,
    parameter int         IDX_W    = 3,
    parameter logic [6:0] DEV_ADDR = 7'h61,
    parameter logic [7:0] CTRL_A   = 8'h8E,
    parameter logic [7:0] CTRL_B   = 8'hF0
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [DIV_W-1:0] div,
    output logic [7:0]       byte_o
);
    always_comb begin
        case (idx)
            IDX_W'(0): byte_o = {DEV_ADDR, 1'b0};
            IDX_W'(1): byte_o = div[DIV_W-1 -: 8];
            IDX_W'(2): byte_o = div[7:0];
            IDX_W'(3): byte_o = CTRL_A;
            default:   byte_o = CTRL_B;
        endcase
    end
endmodule

// File: rtl/pll_tune_ctrl.sv
module pll_tune_ctrl
    import pll_tune_pkg::*;
#(
    parameter int         IF_STEPS = 3836,
    parameter int         QDIV     = 4,
    parameter logic [6:0] DEV_ADDR = 7'h61,
    parameter logic [7:0] CTRL_A   = 8'h8E,
    parameter logic [7:0] CTRL_B   = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] rx_code_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NBYTES - 1);
    localparam logic [BIT_W-1:0] ACK_BIT   = BIT_W'(8);

    tune_state_t       q, d;
    logic              tick;
    logic [DIV_W-1:0]  sum_div;
    logic              sum_ovf;
    logic [IDX_W-1:0]  mux_idx;
    logic [7:0]        next_byte;
    logic              scl_hi, sda_hi;

    pt_quarter_tick #(.QDIV(QDIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(q.busy), .tick(tick)
    );

    pt_divider_calc #(.DIV_W(DIV_W), .IF_STEPS(IF_STEPS)) u_calc (
        .code(rx_code_i), .div(sum_div), .ovf(sum_ovf)
    );

    assign mux_idx = (q.st == PH_BITS) ? IDX_W'(q.byten + 1'b1) : '0;

    pt_frame_mux #(
        .DIV_W(DIV_W), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR),
        .CTRL_A(CTRL_A), .CTRL_B(CTRL_B)
    ) u_mux (
        .idx(mux_idx), .div(q.div), .byte_o(next_byte)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.st == PH_IDLE) begin
            if (start_i) begin
                if (sum_ovf) begin
                    d.err  = 1'b1;
                    d.done = 1'b1;
                end else begin
                    d.st    = PH_START;
                    d.busy  = 1'b1;
                    d.err   = 1'b0;
                    d.div   = sum_div;
                    d.qtr   = '0;
                    d.bitn  = '0;
                    d.byten = '0;
                    d.nack  = 1'b0;
                end
            end
        end else if (tick) begin
            d.qtr = q.qtr + 2'd1;
            case (q.st)
                PH_START: begin
                    if (q.qtr == 2'd3) begin
                        d.st    = PH_BITS;
                        d.sh    = next_byte;
                        d.bitn  = '0;
                        d.byten = '0;
                    end
                end
                PH_BITS: begin
                    if (q.qtr == 2'd1 && q.bitn == ACK_BIT) d.nack = sda_i;
                    if (q.qtr == 2'd3) begin
                        if (q.bitn == ACK_BIT) begin
                            if (q.nack || q.byten == LAST_BYTE) begin
                                d.st  = PH_STOP;
                                d.err = q.nack;
                            end else begin
                                d.byten = q.byten + 1'b1;
                                d.sh    = next_byte;
                                d.bitn  = '0;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.sh   = {q.sh[6:0], 1'b0};
                        end
                    end
                end
                PH_STOP: begin
                    if (q.qtr == 2'd3) begin
                        d.st   = PH_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Line levels by quarter: START drops SDA mid-high, STOP raises it mid-high.
    always_comb begin
        case (q.st)
            PH_START: begin
                scl_hi = (q.qtr != 2'd3);
                sda_hi = (q.qtr == 2'd0);
            end
            PH_BITS: begin
                scl_hi = (q.qtr == 2'd1) || (q.qtr == 2'd2);
                sda_hi = (q.bitn == ACK_BIT) ? 1'b1 : q.sh[7];
            end
            PH_STOP: begin
                scl_hi = (q.qtr != 2'd0);
                sda_hi = q.qtr[1];
            end
            default: begin
                scl_hi = 1'b1;
                sda_hi = 1'b1;
            end
        endcase
    end

    assign scl_oe_o = ~scl_hi;
    assign sda_oe_o = ~sda_hi;
    assign busy_o   = q.busy;
    assign done_o   = q.done;
    assign err_o    = q.err;
endmodule

// File: rtl/pll_tune_ctrl_chk.sv
module pll_tune_ctrl_chk #(
    parameter int DIV_W    = 16,
    parameter int IF_STEPS = 3836
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [DIV_W-1:0] rx_code_i,
    input logic             scl_oe_o,
    input logic             sda_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o
);
    localparam logic [DIV_W-1:0] LIMIT = DIV_W'((1 << DIV_W) - 1 - IF_STEPS);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8

    AST_OVF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && rx_code_i > LIMIT) |=> (!busy_o && err_o && done_o)); // R7

    AST_ACCEPT_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && rx_code_i <= LIMIT) |=> (busy_o && !err_o)); // R10

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R8
endmodule

bind pll_tune_ctrl pll_tune_ctrl_chk #(.DIV_W(16), .IF_STEPS(IF_STEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_code_i(rx_code_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
);

// File: tb/pll_tune_ctrl_bench.sv
module pll_tune_ctrl_bench;
    localparam int QDIV   = 4;
    localparam int IFS    = 3836;
    localparam int LIMIT  = 65535 - IFS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] rx_code_i = '0;
    logic        scl_oe, sda_oe, busy_o, done_o, err_o;
    logic        slave_pull = 1'b0;
    wire         scl_bus = ~scl_oe;
    wire         sda_bus = ~(sda_oe | slave_pull);

    always #4 clk = ~clk;

    pll_tune_ctrl #(.IF_STEPS(IFS), .QDIV(QDIV)) u_pll_tune_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_code_i(rx_code_i),
        .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int n_chk = 0, n_bad = 0;
    int nack_byte = -1;
    int n_start = 0, n_stop = 0, mism = 0;
    int mbits = 0, sl_cnt = 0, sl_byte = 0;
    logic [7:0] mcur = '0;
    int mon_bytes[$];

    // Behavioural reference: remaining busy cycles and done pulse.
    int   m_rem = 0;
    logic m_done = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rem  <= 0;
            m_done <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (m_rem > 0) begin
                m_rem <= m_rem - 1;
                if (m_rem == 1) m_done <= 1'b1;
            end else if (start_i) begin
                if (int'(rx_code_i) > LIMIT) m_done <= 1'b1;
                else m_rem <= (nack_byte < 0 ? 188 : 8 + 36 * (nack_byte + 1)) * QDIV;
            end
        end
    end

    always @(negedge clk)
        if (rst_n && (busy_o !== (m_rem > 0) || done_o !== m_done)) mism++;

    // Bus monitor and acknowledging slave.
    always @(negedge sda_bus)
        if (rst_n && scl_bus === 1'b1) begin
            n_start++; mbits = 0; sl_cnt = -1; sl_byte = 0; slave_pull = 1'b0;
        end
    always @(posedge sda_bus)
        if (rst_n && scl_bus === 1'b1) n_stop++;
    always @(posedge scl_bus)
        if (rst_n) begin
            if (mbits < 8) begin mcur = {mcur[6:0], sda_bus}; mbits++; end
            else begin mon_bytes.push_back(int'(mcur)); mbits = 0; end
        end
    always @(negedge scl_bus)
        if (rst_n) begin
            sl_cnt++;
            if (sl_cnt == 8) slave_pull = (sl_byte != nack_byte);
            else if (sl_cnt == 9) begin slave_pull = 1'b0; sl_cnt = 0; sl_byte++; end
        end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // mid: 0 none, 1 strobe mid-transfer, 2 strobe in last busy cycle
    task automatic run_op(input int code, input int nk, input int mid);
        int exp_b[5];
        int dv = code + IFS;
        int nexp;
        int cyc = 0;
        logic err_seen;
        exp_b[0] = 8'hC2; exp_b[1] = (dv >> 8) & 255; exp_b[2] = dv & 255;
        exp_b[3] = 8'h8E; exp_b[4] = 8'hF0;
        nack_byte = nk; mon_bytes.delete(); n_start = 0; n_stop = 0; mism = 0;
        @(negedge clk);
        start_i = 1'b1; rx_code_i = code[15:0];
        @(negedge clk);
        while (!done_o) begin
            start_i = 1'b0;
            if ((mid == 1 && cyc == 100) || (mid == 2 && m_rem == 1)) begin
                start_i = 1'b1; rx_code_i = 16'h1234;
            end
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        err_seen = err_o;
        repeat (6) @(negedge clk);
        chk(busy_o == 1'b0, "R9", "busy after end", int'(busy_o), 0);
        chk(mism == 0, "R8", "busy/done cycle mismatches", mism, 0);
        if (code > LIMIT) begin
            chk(n_start == 0 && mon_bytes.size() == 0, "R7", "bus activity on overflow",
                n_start, 0);
            chk(err_seen == 1'b1, "R7", "err on overflow", int'(err_seen), 1);
        end else begin
            nexp = (nk < 0) ? 5 : nk + 1;
            chk(n_start == 1, "R5", "START count", n_start, 1);
            chk(n_stop == 1, "R5", "STOP count", n_stop, 1);
            chk(mon_bytes.size() == nexp, (nk < 0) ? "R9" : "R6", "byte count",
                mon_bytes.size(), nexp);
            for (int i = 0; i < nexp && i < mon_bytes.size(); i++)
                chk(mon_bytes[i] == exp_b[i], i == 0 ? "R2" : (i < 3 ? "R3" : "R4"),
                    "frame byte", mon_bytes[i], exp_b[i]);
            chk(err_seen == (nk >= 0), (nk >= 0) ? "R6" : "R10", "err at done",
                int'(err_seen), int'(nk >= 0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "status after reset",
            {busy_o, done_o, err_o}, 0);
        chk(scl_oe == 0 && sda_oe == 0, "R1", "lines after reset", {scl_oe, sda_oe}, 0);
        run_op(7280, -1, 0);     // R3 nominal 910 MHz
        run_op(0, -1, 0);        // R3 lowest code
        run_op(LIMIT, -1, 0);    // R3 largest code
        run_op(LIMIT + 1, -1, 0);// R7 overflow
        run_op(1000, -1, 0);     // R10 err cleared
        run_op(2000, 0, 0);      // R6 NACK on address
        run_op(3000, 3, 0);      // R6 NACK on first control byte
        run_op(7280, -1, 1);     // R9 strobe mid-transfer
        run_op(500, -1, 2);      // R9 strobe in last busy cycle
        chk(scl_oe == 0 && sda_oe == 0, "R1", "lines idle at end", {scl_oe, sda_oe}, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule